// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Port

This block is the slave side of an 8-bit parallel host bus for a display controller. A static mode pin chooses how the two strobe pins are read. With the pin high they act as an enable strobe plus a read/write level, in the 6800 style. With the pin low they act as separate active-low read and write strobes, in the 8080 style. The port responds only while an active-low select and an active-high select are both asserted. A register-select input marks each transfer as display data or as command/status.

Every cycle is decoded into one of four transfers: a data write, a data read, a command write or a status read. The data bus output enable is a pure combinational decode of the pins, so the host sees read data as soon as its strobe opens. Write strobes and the end of data reads pass through a multi-flop synchronizer into the core clock domain. There an edge detector turns each one into a single-cycle pulse. Write pulses come with the captured byte. A status read returns the core's busy flag in bit 7. While that flag is set, only status reads have any effect.

Top module: `mpu_bus_port`

## Requirements
- R1: The port is selected only when `cs_n` is 0 and `cs_hi` is 1. In the three other combinations, `db_oe` stays 0 and strobe activity produces no pulse on `cmd_wr_p`, `dat_wr_p` or `dat_rd_p`.
- R2: With `mode_m68` = 1 and `strb_b` (read/write level) = 1, the port drives the bus (`db_oe` = 1) exactly while `strb_a` (enable) is 1.
- R3: With `mode_m68` = 1 and `strb_b` = 0, the byte on `db_in` is taken at the falling edge of `strb_a`.
- R4: With `mode_m68` = 0, the port drives the bus exactly while `strb_a` (active-low read strobe) is 0.
- R5: With `mode_m68` = 0, the byte on `db_in` is taken at the rising edge of `strb_b` (active-low write strobe).
- R6: A write with `rs` = 1 raises `dat_wr_p`. A write with `rs` = 0 raises `cmd_wr_p`. At most one of the three pulse outputs is high in any cycle.
- R7: A read with `rs` = 1 drives `core_rd_data` onto `db_out`. A read with `rs` = 0 drives the status word: bit 7 is `core_busy` and bits 6..0 are `core_stat`.
- R8: While `core_busy` is 1, writes and data reads produce no pulse. Status reads still return the status word with bit 7 = 1.
- R9: Each accepted write gives exactly one pulse, one clock cycle wide, within `SYNC_STAGES`+2 cycles of the strobe's closing edge. `wr_byte` holds the written byte during that pulse.
- R10: Each accepted data read (`rs` = 1) gives exactly one single-cycle `dat_rd_p` pulse after its read strobe closes. Status reads give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_m68 | input | 1 | Static bus style: 1 = enable + read/write level, 0 = separate read/write strobes |
| cs_n | input | 1 | Active-low select |
| cs_hi | input | 1 | Active-high select |
| rs | input | 1 | 1 = display data, 0 = command/status |
| strb_a | input | 1 | Enable (mode 1) or active-low read strobe (mode 0) |
| strb_b | input | 1 | Read/write level (mode 1) or active-low write strobe (mode 0) |
| db_in | input | DW | Data bus input from the pad |
| db_out | output | DW | Data bus value to drive |
| db_oe | output | 1 | Data bus output enable |
| core_busy | input | 1 | Core busy flag |
| core_stat | input | DW-1 | Low status bits from the core |
| core_rd_data | input | DW | Display byte to return on data reads |
| cmd_wr_p | output | 1 | Single-cycle command write pulse |
| dat_wr_p | output | 1 | Single-cycle data write pulse |
| dat_rd_p | output | 1 | Single-cycle data read completion pulse |
| wr_byte | output | DW | Captured write byte, valid with a write pulse |

## Verification
The bench runs writes and reads with `rs` both high and low in each bus style, using bytes 0x00, 0xFF and alternating patterns. This checks that the kind of transfer and every bit lane are decoded correctly, and that the two styles do not mix up their strobe meanings. The same cycles are then repeated under each of the three deselect combinations, which shows that the selects, and not the strobes, gate both the bus drive and the pulses. Last, a busy phase sends writes, a data read and a status read. Only the status read should have any effect, and it should show bit 7 set.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;

  localparam int unsigned LANES     = 3;
  localparam int unsigned LN_WR_CMD = 0;
  localparam int unsigned LN_WR_DAT = 1;
  localparam int unsigned LN_RD_DAT = 2;

  typedef enum logic [2:0] {
    XF_IDLE,
    XF_DATA_WR,
    XF_DATA_RD,
    XF_CMD_WR,
    XF_STAT_RD
  } xfer_e;

  // Both selects must be asserted.
  function automatic logic is_selected(input logic cs_n, input logic cs_hi);
    return ~cs_n & cs_hi;
  endfunction

  // Read window: enable high with rw high, or read strobe low.
  function automatic logic read_level(input logic m68, input logic a, input logic b);
    return m68 ? (a & b) : ~a;
  endfunction

  // Write window: enable high with rw low, or write strobe low.
  function automatic logic write_level(input logic m68, input logic a, input logic b);
    return m68 ? (a & ~b) : ~b;
  endfunction

  function automatic xfer_e classify(input logic sel, input logic m68, input logic rs,
                                     input logic a, input logic b);
    if (!sel)                       return XF_IDLE;
    else if (write_level(m68, a, b)) return rs ? XF_DATA_WR : XF_CMD_WR;
    else if (read_level(m68, a, b))  return rs ? XF_DATA_RD : XF_STAT_RD;
    else                            return XF_IDLE;
  endfunction

endpackage

// File: rtl/mpu_bus_decode.sv
module mpu_bus_decode
  import mpu_bus_pkg::*;
(
  input  logic             mode_m68,
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             rs,
  input  logic             strb_a,
  input  logic             strb_b,
  output logic             drive_en,
  output logic [LANES-1:0] phase
);

  logic  sel;
  xfer_e xfer;

  always_comb begin
    sel      = is_selected(cs_n, cs_hi);
    xfer     = classify(sel, mode_m68, rs, strb_a, strb_b);
    drive_en = sel & read_level(mode_m68, strb_a, strb_b);
    phase    = '0;
    phase[LN_WR_CMD] = (xfer == XF_CMD_WR);
    phase[LN_WR_DAT] = (xfer == XF_DATA_WR);
    phase[LN_RD_DAT] = (xfer == XF_DATA_RD);
  end

endmodule

// File: rtl/mpu_bus_strobe_sync.sv
module mpu_bus_strobe_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] synced,
  output logic [N-1:0] ends
);

  logic [N-1:0] stg [STAGES];
  logic [N-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
      last <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      last <= stg[STAGES-1];
    end
  end

  assign synced = stg[STAGES-1];

  for (genvar g = 0; g < int'(N); g++) begin : g_lane
    assign ends[g] = last[g] & ~synced[g];

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ends[g] |=> !ends[g]); // R9
  end

endmodule

// File: rtl/mpu_bus_capture.sv
module mpu_bus_capture #(
  parameter int unsigned DW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          load,
  output logic [DW-1:0] dout
);

  // Delay the bus by the synchronizer depth so that it lines up with the synced strobe.
  logic [DW-1:0] dly [STAGES];
  logic [DW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) dly[i] <= '0;
      hold <= '0;
    end else begin
      dly[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) dly[i] <= dly[i-1];
      if (load) hold <= dly[STAGES-1];
    end
  end

  assign dout = hold;

endmodule

// File: rtl/mpu_bus_port.sv
module mpu_bus_port
  import mpu_bus_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_m68,
  input  logic          cs_n,
  input  logic          cs_hi,
  input  logic          rs,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  input  logic          core_busy,
  input  logic [DW-2:0] core_stat,
  input  logic [DW-1:0] core_rd_data,
  output logic          cmd_wr_p,
  output logic          dat_wr_p,
  output logic          dat_rd_p,
  output logic [DW-1:0] wr_byte
);

  logic [LANES-1:0] phase;
  logic [LANES-1:0] synced;
  logic [LANES-1:0] ends;
  logic             drive_en;
  logic             wr_load;
  logic [DW-1:0]    status_word;

  mpu_bus_decode u_decode (
    .mode_m68 (mode_m68),
    .cs_n     (cs_n),
    .cs_hi    (cs_hi),
    .rs       (rs),
    .strb_a   (strb_a),
    .strb_b   (strb_b),
    .drive_en (drive_en),
    .phase    (phase)
  );

  mpu_bus_strobe_sync #(.N(LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (phase),
    .synced (synced),
    .ends   (ends)
  );

  assign wr_load = synced[LN_WR_CMD] | synced[LN_WR_DAT];

  mpu_bus_capture #(.DW(DW), .STAGES(SYNC_STAGES)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (db_in),
    .load  (wr_load),
    .dout  (wr_byte)
  );

  // Busy blocks everything except status reads, which create no pulse anyway.
  assign cmd_wr_p = ends[LN_WR_CMD] & ~core_busy;
  assign dat_wr_p = ends[LN_WR_DAT] & ~core_busy;
  assign dat_rd_p = ends[LN_RD_DAT] & ~core_busy;

  assign status_word = {core_busy, core_stat};
  assign db_out      = rs ? core_rd_data : status_word;
  assign db_oe       = drive_en;

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs_hi) |-> !db_oe); // R1
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr_p, dat_wr_p, dat_rd_p})); // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |-> !(cmd_wr_p || dat_wr_p || dat_rd_p)); // R8
  AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe && !rs) |-> (db_out[DW-1] == core_busy)); // R7

endmodule

// File: tb/mpu_bus_port_bench.sv
`timescale 1ns/1ps
module mpu_bus_port_bench;

  typedef struct packed {
    logic [1:0] kind;   // 0 command write, 1 data write, 2 data read
    logic [7:0] b;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_m68 = 1'b1;
  logic       cs_n = 1'b0;
  logic       cs_hi = 1'b1;
  logic       rs = 1'b0;
  logic       strb_a = 1'b0;
  logic       strb_b = 1'b1;
  logic [7:0] db_in = 8'h00;
  logic [7:0] db_out;
  logic       db_oe;
  logic       core_busy = 1'b0;
  logic [6:0] core_stat = 7'h2A;
  logic [7:0] core_rd_data = 8'hC3;
  logic       cmd_wr_p, dat_wr_p, dat_rd_p;
  logic [7:0] wr_byte;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_tag = "R9 idle";
  exp_t  q[$];

  always #5 clk = ~clk;

  mpu_bus_port u_mpu_bus_port (
    .clk(clk), .rst_n(rst_n), .mode_m68(mode_m68), .cs_n(cs_n), .cs_hi(cs_hi),
    .rs(rs), .strb_a(strb_a), .strb_b(strb_b), .db_in(db_in), .db_out(db_out),
    .db_oe(db_oe), .core_busy(core_busy), .core_stat(core_stat),
    .core_rd_data(core_rd_data), .cmd_wr_p(cmd_wr_p), .dat_wr_p(dat_wr_p),
    .dat_rd_p(dat_rd_p), .wr_byte(wr_byte)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every pulse.
  initial forever begin
    @(posedge clk);
    #2;
    if (rst_n && (cmd_wr_p || dat_wr_p || dat_rd_p)) begin
      int k;
      exp_t e;
      k = cmd_wr_p ? 0 : (dat_wr_p ? 1 : 2);
      if (q.size() == 0) begin
        chk(0, {cur_tag, " unexpected pulse"}, k, 3);
      end else begin
        e = q.pop_front();
        chk(e.kind == 2'(k), "R6 R10 pulse kind", k, int'(e.kind));
        if (k != 2) chk(wr_byte == e.b, "R9 captured byte", int'(wr_byte), int'(e.b));
      end
    end
  end

  task automatic drain(input string tag);
    repeat (6) @(negedge clk);
    chk(q.size() == 0, {tag, " pulse count"}, q.size(), 0);
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    mode_m68 = m;
    strb_a   = m ? 1'b0 : 1'b1;
    strb_b   = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic do_write(input bit r, input logic [7:0] d, input string tag);
    bit acc;
    acc = !cs_n && cs_hi && !core_busy;
    cur_tag = tag;
    @(negedge clk);
    rs = r; db_in = d;
    if (mode_m68) strb_b = 1'b0;
    @(negedge clk);
    if (mode_m68) strb_a = 1'b1; else strb_b = 1'b0;
    repeat (3) @(negedge clk);
    if (mode_m68) strb_a = 1'b0; else strb_b = 1'b1;
    if (acc) q.push_back({(r ? 2'd1 : 2'd0), d});
    repeat (2) @(negedge clk);
    if (mode_m68) strb_b = 1'b1;
    db_in = ~d;
    drain(tag);
  endtask

  task automatic do_read(input bit r, input logic [7:0] exp, input string tag);
    bit sel, acc;
    sel = !cs_n && cs_hi;
    acc = sel && r && !core_busy;
    cur_tag = tag;
    @(negedge clk);
    rs = r;
    @(negedge clk);
    if (mode_m68) strb_a = 1'b1; else strb_a = 1'b0;
    repeat (2) @(negedge clk);
    chk(db_oe == sel, {tag, " drive during strobe"}, int'(db_oe), int'(sel));
    if (sel) chk(db_out == exp, {tag, " read value"}, int'(db_out), int'(exp));
    if (mode_m68) strb_a = 1'b0; else strb_a = 1'b1;
    if (acc) q.push_back({2'd2, 8'h00});
    @(negedge clk);
    chk(db_oe == 1'b0, {tag, " release after strobe"}, int'(db_oe), 0);
    drain(tag);
  endtask

  task automatic deselect_sweep(input string tag);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      cs_n  = (c != 1);
      cs_hi = (c == 0);
      do_write(1'b1, 8'h99, tag);
      do_write(1'b0, 8'h66, tag);
      do_read(1'b1, 8'h00, tag);
    end
    @(negedge clk);
    cs_n = 1'b0; cs_hi = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(db_oe == 1'b0, "R2 reset idle no drive", int'(db_oe), 0);
    chk({cmd_wr_p, dat_wr_p, dat_rd_p} == 3'b000, "R9 reset no pulse",
        int'({cmd_wr_p, dat_wr_p, dat_rd_p}), 0);

    // 6800 style
    do_write(1'b0, 8'h5A, "R3 R6 cmd write e-fall");
    do_write(1'b1, 8'hA5, "R3 R6 data write e-fall");
    do_write(1'b1, 8'h00, "R3 data write zero");
    do_write(1'b0, 8'hFF, "R3 cmd write ones");
    do_read(1'b1, 8'hC3, "R2 R7 R10 data read");
    do_read(1'b0, 8'h2A, "R2 R7 R10 status read");
    @(negedge clk); core_rd_data = 8'h3C;
    do_read(1'b1, 8'h3C, "R7 data read new byte");
    deselect_sweep("R1 deselected 6800");

    // 8080 style
    set_mode(1'b0);
    do_write(1'b1, 8'h81, "R5 R6 data write wr-rise");
    do_write(1'b0, 8'h7E, "R5 R6 cmd write wr-rise");
    do_write(1'b1, 8'h55, "R5 data write alt");
    do_read(1'b1, 8'h3C, "R4 R10 data read rd-low");
    do_read(1'b0, 8'h2A, "R4 R7 status read");
    deselect_sweep("R1 deselected 8080");

    // busy phase
    @(negedge clk); core_busy = 1'b1;
    do_write(1'b1, 8'h12, "R8 busy data write");
    do_write(1'b0, 8'h34, "R8 busy cmd write");
    do_read(1'b1, 8'h3C, "R8 busy data read");
    do_read(1'b0, 8'hAA, "R8 R7 busy status read");
    set_mode(1'b1);
    do_write(1'b0, 8'h56, "R8 busy cmd write 6800");
    do_read(1'b0, 8'hAA, "R8 busy status read 6800");
    @(negedge clk); core_busy = 1'b0;
    do_write(1'b1, 8'hC7, "R9 write after busy");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R9 scoreboard empty at end", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule